// File: doc/BRIEF.md
# Multiplexed-address EDO DRAM array model

A synthesizable, clock-sampled model of a dynamic memory that is four bits wide. Row and column addresses share one bus. The block samples a row strobe, four independent column strobes, a write strobe and an output-enable strobe on the system clock. It classifies every access by the order in which those strobes change. The classes are a normal read, an early write, a read-modify-write, and three kinds of refresh. In a RAS-only refresh the row comes from the bus. In a CAS-before-RAS refresh and in a hidden refresh the row comes from an internal counter.

The data bus is split into a value output and a per-bit drive enable, so that a pad ring or a bench can build the tri-state bus. Read data follows extended-data-out rules: it stays driven after a column strobe returns high. A small per-row age tracker raises a flag when any row has gone too long without a refresh. A sticky error output reports a column strobe that falls during a refresh cycle.

All strobes are registered once and compared with their previous sample. The model therefore acts one clock after it samples an edge, which is two clock edges after the pin changes.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, `dq_oe` is 0, `cycle_kind` is 0 (idle), `proto_error` and `retention_error` are 0, and every cell reads as 0.
- R2: A read works as follows. The row is latched when `ras_n` falls with all `cas_n` high. The column is latched when a `cas_n[i]` falls with `we_n` high. Bit i of that word then appears on `dq_out[i]`, with `dq_oe[i]`=1 while `oe_n`=0 and `we_n`=1, and `cycle_kind`=1. Further column strobes while the row stays open read further columns of the same row.
- R3: Read data stays driven after `cas_n` rises while `ras_n` is low, and after `ras_n` rises while a `cas_n` is still low. `dq_oe` clears once `ras_n` and all `cas_n` are high. `oe_n` high also removes the drive, and `oe_n` low again restores it.
- R4: If `we_n` is low when `cas_n[i]` falls, `dq_in[i]` is written to bit i of the addressed cell. `cycle_kind` becomes 2 and `dq_oe` stays 0.
- R5: Each `cas_n[i]` reads or writes only data bit i. The other bits of the cell keep their value.
- R6: If `we_n` falls while a read is open, `dq_in` is written into every bit whose `cas_n` is low, and `cycle_kind` becomes 3. While `we_n` is low, `dq_oe` is 0. After `we_n` rises, `dq_out` still shows the old cell data.
- R7: A `ras_n` fall with all `cas_n` high, followed by no column strobe, gives `cycle_kind`=4 with `dq_oe`=0. It refreshes the row on `addr`.
- R8: A `ras_n` fall while any `cas_n` is already low, with no access data held, is a CAS-before-RAS refresh. `cycle_kind` becomes 5 and `dq_oe` is 0 whatever the values of `oe_n` and `we_n`. The refreshed row comes from an internal counter that advances by one per internal refresh and wraps over 2^ROW_BITS rows.
- R9: If `ras_n` rises and falls again while a `cas_n` stays low after a read, the cycle is a hidden refresh. `cycle_kind` becomes 6, the internal counter is used, and the previous read data stays driven.
- R10: A `cas_n` falling while `ras_n` is low in a type-5 or type-6 cycle sets `proto_error`. The flag stays set until reset.
- R11: `retention_error` is high while any row has gone more than RETAIN_LIMIT clocks without being refreshed, whether by a RAS-only refresh, an internal refresh or an access. It clears once every stale row has been refreshed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 4 | Column strobes, one per data bit, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 4 | Write data from the bus |
| dq_out | output | 4 | Read data toward the bus |
| dq_oe | output | 4 | Per-bit drive enable of the bus |
| cycle_kind | output | 3 | Current cycle class (0 idle, 1 read, 2 early write, 3 read-modify-write, 4 RAS-only, 5 CAS-before-RAS, 6 hidden) |
| proto_error | output | 1 | Sticky strobe-order error |
| retention_error | output | 1 | Some row exceeds the refresh age limit |

## Verification
The bench targets the cases where strobe order alone separates one class from another:
- A read left standing with a column strobe low, then a row strobe toggle, must become a hidden refresh with its data still driven. A design that confused it with CAS-before-RAS would drop the bus.
- A write that uses one column strobe must leave the other three bits intact. A design that wrote the whole word would corrupt them.
- A read-modify-write must show the old data once the write strobe returns high.
- The refresh-counter check runs seven internal refreshes, which must leave one stale row, and an eighth, which must clear the age flag. A counter that skipped or failed to wrap would leave the flag high.

// File: rtl/edo_pkg.sv
package edo_pkg;

    localparam int LANES = 4;

    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_READ    = 3'd1,
        CYC_EWRITE  = 3'd2,
        CYC_RMW     = 3'd3,
        CYC_RASONLY = 3'd4,
        CYC_CBR     = 3'd5,
        CYC_HIDDEN  = 3'd6
    } cyc_kind_e;

    typedef struct packed {
        logic             ras;
        logic [LANES-1:0] cas;
        logic             we;
        logic             oe;
    } strobe_t;

endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync
    import edo_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           strb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  din_i,
    output strobe_t           cur_o,
    output logic              ras_fall_o,
    output logic              ras_rise_o,
    output logic [LANES-1:0]  cas_fall_o,
    output logic              we_fall_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  din_o
);

    typedef struct packed {
        strobe_t           cur;
        strobe_t           prv;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  din;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.prv  = sync_q.cur;
        sync_d.cur  = strb_i;
        sync_d.addr = addr_i;
        sync_d.din  = din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.cur  <= '1;
            sync_q.prv  <= '1;
            sync_q.addr <= '0;
            sync_q.din  <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cur_o      = sync_q.cur;
    assign ras_fall_o = sync_q.prv.ras & ~sync_q.cur.ras;
    assign ras_rise_o = ~sync_q.prv.ras & sync_q.cur.ras;
    assign cas_fall_o = sync_q.prv.cas & ~sync_q.cur.cas;
    assign we_fall_o  = sync_q.prv.we & ~sync_q.cur.we;
    assign addr_o     = sync_q.addr;
    assign din_o      = sync_q.din;

endmodule

// File: rtl/edo_age_tracker.sv
module edo_age_tracker #(
    parameter int ROW_BITS     = 3,
    parameter int RETAIN_LIMIT = 400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_v_i,
    input  logic [ROW_BITS-1:0] ref_row_i,
    output logic                stale_o
);

    localparam int ROWS  = 1 << ROW_BITS;
    localparam int CNT_W = $clog2(RETAIN_LIMIT + 2);

    logic [ROWS-1:0][CNT_W-1:0] age_d, age_q;
    logic [ROWS-1:0]            stale;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign stale[r] = (age_q[r] > CNT_W'(RETAIN_LIMIT));
    end

    always_comb begin
        age_d = age_q;
        for (int r = 0; r < ROWS; r++) begin
            if (ref_v_i && (ref_row_i == ROW_BITS'(r))) begin
                age_d[r] = '0;
            end else if (!stale[r]) begin
                age_d[r] = age_q[r] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

    assign stale_o = |stale;

    AST_STALE_NEEDS_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stale_o) |-> $past(ref_v_i)); // R11

endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
    import edo_pkg::*;
#(
    parameter int ROW_BITS     = 3,
    parameter int COL_BITS     = 3,
    parameter int RETAIN_LIMIT = 400,
    localparam int ADDR_W      = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [3:0]        cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic [2:0]        cycle_kind,
    output logic              proto_error,
    output logic              retention_error
);

    localparam int WORDS = 1 << (ROW_BITS + COL_BITS);

    typedef struct packed {
        logic [WORDS-1:0][LANES-1:0]    mem;
        logic [ROW_BITS-1:0]            row;
        logic [LANES-1:0][COL_BITS-1:0] col;
        logic [ROW_BITS-1:0]            rfc;
        logic [LANES-1:0]               dout;
        logic [LANES-1:0]               valid;
        cyc_kind_e                      kind;
        logic                           hold;
        logic                           perr;
    } st_t;

    st_t st_d, st_q;

    strobe_t             cur;
    logic                ras_fall, ras_rise, we_fall;
    logic [LANES-1:0]    cas_fall;
    logic [ADDR_W-1:0]   addr_s;
    logic [LANES-1:0]    din_s;
    logic                ref_v;
    logic [ROW_BITS-1:0] ref_row;
    logic                cas_any_low, all_high, row_open;

    edo_strobe_sync #(.ADDR_W(ADDR_W)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strb_i     ({ras_n, cas_n, we_n, oe_n}),
        .addr_i     (addr),
        .din_i      (dq_in),
        .cur_o      (cur),
        .ras_fall_o (ras_fall),
        .ras_rise_o (ras_rise),
        .cas_fall_o (cas_fall),
        .we_fall_o  (we_fall),
        .addr_o     (addr_s),
        .din_o      (din_s)
    );

    function automatic int widx(logic [ROW_BITS-1:0] r, logic [COL_BITS-1:0] c);
        return int'({r, c});
    endfunction

    assign cas_any_low = ~&cur.cas;
    assign all_high    = cur.ras & (&cur.cas);
    assign row_open    = ~cur.ras && (st_q.kind inside {CYC_READ, CYC_EWRITE, CYC_RMW, CYC_RASONLY});

    always_comb begin
        st_d    = st_q;
        ref_v   = 1'b0;
        ref_row = '0;

        // row strobe falling: classify refresh versus access
        if (ras_fall) begin
            ref_v = 1'b1;
            if (cas_any_low) begin
                ref_row  = st_q.rfc;
                st_d.rfc = st_q.rfc + 1'b1;
                if (st_q.hold) begin
                    st_d.kind = CYC_HIDDEN;
                end else begin
                    st_d.kind  = CYC_CBR;
                    st_d.valid = '0;
                end
            end else begin
                ref_row   = addr_s[ROW_BITS-1:0];
                st_d.row  = addr_s[ROW_BITS-1:0];
                st_d.kind = CYC_RASONLY;
            end
        end

        // column strobes falling inside an open row
        if (!cur.ras && (cas_fall != '0)) begin
            if (st_q.kind inside {CYC_CBR, CYC_HIDDEN}) begin
                st_d.perr = 1'b1;
            end else if (row_open) begin
                if (!cur.we) begin
                    st_d.kind  = CYC_EWRITE;
                    st_d.valid = '0;
                end else begin
                    st_d.kind = CYC_READ;
                end
                for (int i = 0; i < LANES; i++) begin
                    if (cas_fall[i]) begin
                        st_d.col[i] = addr_s[COL_BITS-1:0];
                        if (!cur.we) begin
                            st_d.mem[widx(st_q.row, addr_s[COL_BITS-1:0])][i] = din_s[i];
                        end else begin
                            st_d.dout[i]  = st_q.mem[widx(st_q.row, addr_s[COL_BITS-1:0])][i];
                            st_d.valid[i] = 1'b1;
                        end
                    end
                end
            end
        end else if (we_fall && !cur.ras && (st_q.kind == CYC_READ)) begin
            // write strobe after read data: read-modify-write
            st_d.kind = CYC_RMW;
            for (int i = 0; i < LANES; i++) begin
                if (!cur.cas[i] && st_q.valid[i]) begin
                    st_d.mem[widx(st_q.row, st_q.col[i])][i] = din_s[i];
                end
            end
        end

        if (ras_rise) begin
            st_d.hold = cas_any_low && (|st_q.valid);
        end

        if (all_high) begin
            st_d.valid = '0;
            st_d.hold  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem   <= '0;
            st_q.row   <= '0;
            st_q.col   <= '0;
            st_q.rfc   <= '0;
            st_q.dout  <= '0;
            st_q.valid <= '0;
            st_q.kind  <= CYC_IDLE;
            st_q.hold  <= 1'b0;
            st_q.perr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    edo_age_tracker #(.ROW_BITS(ROW_BITS), .RETAIN_LIMIT(RETAIN_LIMIT)) i_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_v_i   (ref_v),
        .ref_row_i (ref_row),
        .stale_o   (retention_error)
    );

    assign dq_out      = st_q.dout;
    assign dq_oe       = st_q.valid & {LANES{~cur.oe & cur.we}};
    assign cycle_kind  = st_q.kind;
    assign proto_error = st_q.perr;

    AST_CBR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CYC_CBR) |-> (dq_oe == '0)); // R8

    AST_EWRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.kind == CYC_EWRITE) |-> (dq_oe == '0)); // R4

    AST_IDLE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        all_high |=> (dq_oe == '0)); // R3

    AST_RFC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && cas_any_low) |=> (st_q.rfc == ROW_BITS'($past(st_q.rfc) + 1'b1))); // R8

    AST_HIDDEN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && cas_any_low && st_q.hold) |=> (st_q.valid == $past(st_q.valid))); // R9

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_error |=> proto_error); // R10

endmodule

// File: tb/test_edo_dram_model.sv
module test_edo_dram_model;

    localparam int LIMIT = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic [3:0] cas_n = 4'hF;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out, dq_oe;
    logic [2:0] cycle_kind;
    logic       proto_error, retention_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    edo_dram_model #(.ROW_BITS(3), .COL_BITS(3), .RETAIN_LIMIT(LIMIT)) i_edo_dram_model (
        .clk             (clk),
        .rst_n           (rst_n),
        .ras_n           (ras_n),
        .cas_n           (cas_n),
        .we_n            (we_n),
        .oe_n            (oe_n),
        .addr            (addr),
        .dq_in           (dq_in),
        .dq_out          (dq_out),
        .dq_oe           (dq_oe),
        .cycle_kind      (cycle_kind),
        .proto_error     (proto_error),
        .retention_error (retention_error)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic close_all();
        cas_n = 4'hF; ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        tick(3);
    endtask

    task automatic open_row(input logic [2:0] r);
        addr = r; ras_n = 1'b0;
        tick(3);
    endtask

    task automatic write_word(input logic [2:0] r, input logic [2:0] c,
                              input logic [3:0] d, input logic [3:0] mask);
        open_row(r);
        we_n = 1'b0; addr = c; dq_in = d; cas_n = ~mask;
        tick(3);
        chk("R4", "early write kind", 8'(cycle_kind), 8'd2);
        chk("R4", "early write dq_oe", 8'(dq_oe), 8'h0);
        close_all();
    endtask

    task automatic start_read(input logic [2:0] r, input logic [2:0] c);
        open_row(r);
        addr = c; cas_n = 4'h0;
        tick(3);
    endtask

    task automatic t_reset();
        chk("R1", "reset dq_oe", 8'(dq_oe), 8'h0);
        chk("R1", "reset kind", 8'(cycle_kind), 8'd0);
        chk("R1", "reset proto_error", 8'(proto_error), 8'd0);
        chk("R1", "reset retention_error", 8'(retention_error), 8'd0);
        start_read(3'd0, 3'd0);
        chk("R1", "reset cell value", 8'(dq_out), 8'h0);
        close_all();
    endtask

    task automatic t_read_edo();
        write_word(3'd2, 3'd5, 4'hA, 4'hF);
        start_read(3'd2, 3'd5);
        chk("R2", "read data", 8'(dq_out), 8'hA);
        chk("R2", "read dq_oe", 8'(dq_oe), 8'hF);
        chk("R2", "read kind", 8'(cycle_kind), 8'd1);
        cas_n = 4'hF; tick(3);
        chk("R3", "drive after CAS high", 8'(dq_oe), 8'hF);
        chk("R3", "data after CAS high", 8'(dq_out), 8'hA);
        oe_n = 1'b1; tick(3);
        chk("R3", "OE high releases", 8'(dq_oe), 8'h0);
        oe_n = 1'b0; tick(3);
        chk("R3", "OE low restores", 8'(dq_oe), 8'hF);
        ras_n = 1'b1; tick(3);
        chk("R3", "all strobes high releases", 8'(dq_oe), 8'h0);
        close_all();
    endtask

    task automatic t_per_bit();
        write_word(3'd2, 3'd5, 4'h5, 4'b0010);
        start_read(3'd2, 3'd5);
        chk("R5", "single-bit write result", 8'(dq_out), 8'h8);
        close_all();
    endtask

    task automatic t_page();
        start_read(3'd2, 3'd5);
        chk("R2", "page first column", 8'(dq_out), 8'h8);
        cas_n = 4'hF; tick(3);
        addr = 3'd0; cas_n = 4'h0; tick(3);
        chk("R2", "page second column", 8'(dq_out), 8'h0);
        chk("R2", "page second dq_oe", 8'(dq_oe), 8'hF);
        close_all();
    endtask

    task automatic t_rmw();
        write_word(3'd3, 3'd1, 4'hC, 4'hF);
        start_read(3'd3, 3'd1);
        chk("R6", "old data before write", 8'(dq_out), 8'hC);
        dq_in = 4'h3; we_n = 1'b0; tick(3);
        chk("R6", "rmw kind", 8'(cycle_kind), 8'd3);
        chk("R6", "dq_oe while WE low", 8'(dq_oe), 8'h0);
        we_n = 1'b1; tick(3);
        chk("R6", "old data after WE high", 8'(dq_out), 8'hC);
        chk("R6", "drive after WE high", 8'(dq_oe), 8'hF);
        close_all();
        start_read(3'd3, 3'd1);
        chk("R6", "new data after rmw", 8'(dq_out), 8'h3);
        close_all();
    endtask

    task automatic t_ras_only();
        open_row(3'd4);
        chk("R7", "RAS-only kind", 8'(cycle_kind), 8'd4);
        chk("R7", "RAS-only dq_oe", 8'(dq_oe), 8'h0);
        close_all();
    endtask

    task automatic t_hidden();
        start_read(3'd3, 3'd1);
        ras_n = 1'b1; tick(3);
        chk("R3", "drive after RAS high with CAS low", 8'(dq_oe), 8'hF);
        ras_n = 1'b0; tick(3);
        chk("R9", "hidden kind", 8'(cycle_kind), 8'd6);
        chk("R9", "hidden dq_oe", 8'(dq_oe), 8'hF);
        chk("R9", "hidden data", 8'(dq_out), 8'h3);
        close_all();
        chk("R9", "released after hidden", 8'(dq_oe), 8'h0);
    endtask

    task automatic t_cbr_error();
        chk("R10", "no error yet", 8'(proto_error), 8'd0);
        cas_n = 4'h0; tick(3);
        ras_n = 1'b0; tick(3);
        chk("R8", "CBR kind", 8'(cycle_kind), 8'd5);
        chk("R8", "CBR dq_oe with OE low", 8'(dq_oe), 8'h0);
        chk("R10", "CBR alone no error", 8'(proto_error), 8'd0);
        cas_n = 4'b0001; tick(3);
        cas_n = 4'b0000; tick(3);
        chk("R10", "CAS fall during CBR", 8'(proto_error), 8'd1);
        close_all();
        tick(5);
        chk("R10", "error sticky", 8'(proto_error), 8'd1);
    endtask

    task automatic one_cbr();
        cas_n = 4'h0; tick(2);
        ras_n = 1'b0; tick(3);
        ras_n = 1'b1; tick(2);
        cas_n = 4'hF; tick(2);
    endtask

    task automatic t_retention();
        tick(LIMIT + 20);
        chk("R11", "stale after idle", 8'(retention_error), 8'd1);
        for (int r = 0; r < 8; r++) begin
            addr = 3'(r); ras_n = 1'b0; tick(3);
            ras_n = 1'b1; tick(3);
        end
        chk("R7", "RAS-only sweep clears age", 8'(retention_error), 8'd0);
        tick(LIMIT + 20);
        chk("R11", "stale again", 8'(retention_error), 8'd1);
        for (int k = 0; k < 7; k++) one_cbr();
        chk("R8", "seven internal refreshes leave one row", 8'(retention_error), 8'd1);
        one_cbr();
        chk("R8", "eighth internal refresh wraps and clears", 8'(retention_error), 8'd0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_read_edo();
        t_per_bit();
        t_page();
        t_rmw();
        t_ras_only();
        t_hidden();
        t_cbr_error();
        t_retention();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule